// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Control Bank

This block is the shared control register bank of a multi-channel pulse-width modulator. It keeps the run/stop state of every channel and the period-complete interrupts of every channel. Software reaches it over a simple memory-mapped bus. Channels are started and stopped through a separate pair of write-one strobe registers, so that one channel can be changed without a read-modify-write of the others. The interrupt mask is handled the same way. A pending-event register collects one event per completed period from each channel counter and clears itself when read.

The block drives a run line to each channel counter and takes a period-complete pulse back from each. It raises one combined interrupt line. It also decodes the banked per-channel register window and tells the channel bank which channel and which word offset an access targets. The counters, clock dividers and pin multiplexing sit outside this block. The 32-bit mode register is stored here and presented on an output so that the divider logic can use it.

Top module: `pwmctl_top`

## Requirements
- R1: After a synchronous active-low reset, every channel is stopped, every mask bit and pending bit is zero, the mode output is zero and the interrupt line is low.
- R2: A write to byte offset 0x04 starts each channel n whose bit n is 1 in the write data. Channels whose bit is 0 keep their state. The run state reads back at offset 0x0C, with bit n standing for channel n.
- R3: A write to byte offset 0x08 stops each channel whose bit is 1 and leaves the others unchanged.
- R4: Write-data bits at positions NCH and above have no effect. In every per-channel readback, bits at positions NCH and above read as zero.
- R5: A write to 0x10 sets mask bits and a write to 0x14 clears them, both in the write-one manner. The mask reads back at 0x18. Writes to 0x0C, 0x18 and 0x1C change nothing.
- R6: A period-complete pulse on a channel's event line makes that channel's bit at 0x1C pending. A read of 0x1C returns the pending bits and clears them in the same access.
- R7: An event that arrives in the same cycle as a read of 0x1C is not part of that read's data. It stays pending for the next read.
- R8: The interrupt line is high exactly when some channel is both pending and unmasked.
- R9: Offset 0x00 is a 32-bit read/write mode register, and its value is driven on the mode output.
- R10: An access at byte address 0x200 + 0x20*n + k, with n < NCH and 0 <= k < 0x20, raises the window select with channel n and word offset k, in the same cycle. Addresses below 0x200, and addresses of channels n >= NCH, do not raise it.
- R11: Read data appears on the read data port in the cycle after the read request. Only word-aligned global offsets 0x00 to 0x1C return register data. Any other read, and any cycle without a read, gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| mode_cfg | output | 32 | Contents of the mode register |
| chan_en | output | NCH | Run line to each channel counter |
| chan_evt | input | NCH | Period-complete pulse from each channel counter |
| irq | output | 1 | Combined interrupt |
| win_sel | output | 1 | Access falls in the banked per-channel window |
| win_chan | output | 5 | Channel addressed in the window |
| win_off | output | 5 | Byte offset inside the channel's 0x20 slot |

## Verification
The bench builds the block with its default values: four channels and a 12-bit address. Four channels leave write-data bits 4 to 31 outside the channel range, so the bench can show that they are ignored. They also place window slots for channels 4 and up inside the address space, so the bench can show that those slots are rejected. The 12-bit address covers the whole window for 32 channels. A reference model in the bench tracks enables, mask, pending events and read data on every clock. It is driven with directed sequences and then with a long stream of mixed accesses and random event pulses. That stream includes reads of the pending register that collide with new events.

// File: rtl/pwmctl_pkg.sv
// Package: shared constants and the global register index for the PWM control bank.
// Assumes word-aligned 32-bit registers. The index of each global register equals
// its byte offset divided by four.
package pwmctl_pkg;
    localparam int REG_W      = 32;     // bus data width
    localparam int MAX_CH     = 32;     // address layout limit on channel count
    localparam int CH_IDX_W   = 5;      // bits to name one of MAX_CH channels
    localparam int SLOT_W     = 5;      // log2 of the per-channel byte stride
    localparam int WIN_BASE   = 'h200;  // first byte of the per-channel window
    localparam int GLOB_TOP_W = 5;      // global registers fill bytes 0x00..0x1F

    typedef enum logic [2:0] {
        G_MODE   = 3'd0,  // 0x00 mode, read/write
        G_START  = 3'd1,  // 0x04 write-one start
        G_STOP   = 3'd2,  // 0x08 write-one stop
        G_RUN    = 3'd3,  // 0x0C run state, read only
        G_IRQON  = 3'd4,  // 0x10 write-one mask set
        G_IRQOFF = 3'd5,  // 0x14 write-one mask clear
        G_MASK   = 3'd6,  // 0x18 mask readback
        G_PEND   = 3'd7   // 0x1C pending events, clear on read
    } greg_e;
endpackage

// File: rtl/pwmctl_decode.sv
// Module: address decoder. It sorts a bus address into the global register block
// or the banked per-channel window.
// Assumes ADDR_W >= 11, so that the window for MAX_CH channels fits. Global
// registers match only word-aligned addresses.
module pwmctl_decode
    import pwmctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic                bus_sel,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                glob_hit,
    output greg_e               glob_reg,
    output logic                win_sel,
    output logic [CH_IDX_W-1:0] win_chan,
    output logic [SLOT_W-1:0]   win_off
);
    localparam int SLOT_IDX_W = ADDR_W - SLOT_W;

    logic [SLOT_IDX_W-1:0] slot_idx;

    // Global block: word-aligned address in the first 32 bytes.
    always_comb begin
        glob_hit = (bus_addr[ADDR_W-1:GLOB_TOP_W] == '0) && (bus_addr[1:0] == 2'b00);
        glob_reg = greg_e'(bus_addr[4:2]);
    end

    // Window: slot number relative to the window base, bounded by NCH.
    always_comb begin
        slot_idx = bus_addr[ADDR_W-1:SLOT_W] - SLOT_IDX_W'(WIN_BASE >> SLOT_W);
        win_sel  = bus_sel && (bus_addr >= ADDR_W'(WIN_BASE))
                   && (slot_idx < SLOT_IDX_W'(NCH));
        win_chan = slot_idx[CH_IDX_W-1:0];
        win_off  = bus_addr[SLOT_W-1:0];
    end
endmodule

// File: rtl/pwmctl_w1sc.sv
// Module: a bit vector with write-one-to-set and write-one-to-clear strobes.
// Assumes the two strobes never fire in the same cycle. They come from
// different addresses.
module pwmctl_w1sc #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    // Merge the strobed ones into the held vector.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (set_stb) q <= q | bits;
        else if (clr_stb) q <= q & ~bits;
    end
endmodule

// File: rtl/pwmctl_pend.sv
// Module: pending period-event collector that clears when read.
// Assumes each event is a one-cycle pulse. A new event wins over a clear in the
// same cycle, so no event is lost.
module pwmctl_pend #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] pend
);
    // Clear everything on a status read, then OR in this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (rd_clr ? '0 : pend) | evt;
    end
endmodule

// File: rtl/pwmctl_top.sv
// Module: control bank of a multi-channel PWM. It holds the channel run
// states, the interrupt mask, the pending period events and the mode
// register, and it decodes the per-channel register window.
// Assumes 1 <= NCH <= 32, a single-cycle bus and read data registered one
// cycle after the request.
module pwmctl_top
    import pwmctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [REG_W-1:0]    mode_cfg,
    output logic [NCH-1:0]      chan_en,
    input  logic [NCH-1:0]      chan_evt,
    output logic                irq,
    output logic                win_sel,
    output logic [CH_IDX_W-1:0] win_chan,
    output logic [SLOT_W-1:0]   win_off
);
    logic             glob_hit;
    greg_e            glob_reg;
    logic             wr_stb;
    logic             rd_stb;
    logic [NCH-1:0]   wbits;
    logic [NCH-1:0]   mask_q;
    logic [NCH-1:0]   pend_q;
    logic [REG_W-1:0] mode_q;
    logic [REG_W-1:0] rd_val;

    pwmctl_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .glob_hit(glob_hit),
        .glob_reg(glob_reg),
        .win_sel (win_sel),
        .win_chan(win_chan),
        .win_off (win_off)
    );

    // Qualify bus strobes for the global block and keep only the channel bits.
    always_comb begin
        wr_stb = bus_sel && bus_wr && glob_hit;
        rd_stb = bus_sel && !bus_wr && glob_hit;
        wbits  = bus_wdata[NCH-1:0];
    end

    pwmctl_w1sc #(.W(NCH)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_stb(wr_stb && glob_reg == G_START),
        .clr_stb(wr_stb && glob_reg == G_STOP),
        .bits   (wbits),
        .q      (chan_en)
    );

    pwmctl_w1sc #(.W(NCH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_stb(wr_stb && glob_reg == G_IRQON),
        .clr_stb(wr_stb && glob_reg == G_IRQOFF),
        .bits   (wbits),
        .q      (mask_q)
    );

    pwmctl_pend #(.W(NCH)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (chan_evt),
        .rd_clr(rd_stb && glob_reg == G_PEND),
        .pend  (pend_q)
    );

    // Mode register: plain 32-bit store for the divider logic.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mode_q <= '0;
        else if (wr_stb && glob_reg == G_MODE) mode_q <= bus_wdata;
    end

    // Readback selection among the readable global registers.
    always_comb begin
        case (glob_reg)
            G_MODE:  rd_val = mode_q;
            G_RUN:   rd_val = REG_W'(chan_en);
            G_MASK:  rd_val = REG_W'(mask_q);
            G_PEND:  rd_val = REG_W'(pend_q);
            default: rd_val = '0;
        endcase
    end

    // Register read data one cycle after the request, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    // Combined interrupt from pending and unmasked channels.
    always_comb begin
        mode_cfg = mode_q;
        irq      = |(pend_q & mask_q);
    end
endmodule

// File: rtl/pwmctl_chk.sv
// Module: property checker for pwmctl_top, attached through bind.
// Assumes the same parameters as the instance it is bound to.
module pwmctl_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    wbits,
    input logic [31:0]       bus_rdata,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    chan_evt,
    input logic              irq,
    input logic [NCH-1:0]    mask_q,
    input logic [NCH-1:0]    pend_q
);
    // R2: a start write ORs the written bits into the run state.
    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h04))
        |=> chan_en == ($past(chan_en) | $past(wbits)));

    // R3: a stop write clears only the written bits.
    a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h08))
        |=> chan_en == ($past(chan_en) & ~$past(wbits)));

    // R5: a mask-set write ORs bits into the mask.
    a_r5_mask_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(32'h10))
        |=> mask_q == ($past(mask_q) | $past(wbits)));

    // R6: a pending read returns the bits held before the read.
    a_r6_read_returns_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(32'h1C))
        |=> bus_rdata == 32'($past(pend_q)));

    // R7: an event is pending in the next cycle, whether or not a read occurred.
    a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(chan_evt)) == $past(chan_evt)));

    // R8: with the mask empty, the interrupt stays low.
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

bind pwmctl_top pwmctl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbits    (bus_wdata[NCH-1:0]),
    .bus_rdata(bus_rdata),
    .chan_en  (chan_en),
    .chan_evt (chan_evt),
    .irq      (irq),
    .mask_q   (mask_q),
    .pend_q   (pend_q)
);

// File: tb/tb_pwmctl_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is updated on each rising edge. The
// design outputs are compared with it 1 ns after each falling edge.
module tb_pwmctl_top;
    localparam int NCH    = 4;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       mode_cfg;
    logic [NCH-1:0]    chan_en;
    logic [NCH-1:0]    chan_evt = '0;
    logic              irq;
    logic              win_sel;
    logic [4:0]        win_chan;
    logic [4:0]        win_off;

    pwmctl_top #(.NCH(NCH), .ADDR_W(ADDR_W)) dut (.*);

    always #2.5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string cur_tag = "R1";
    string rd_tag = "R11";

    // Reference model state
    logic [31:0]    m_mode = '0;
    logic [NCH-1:0] m_en = '0, m_mask = '0, m_pend = '0;
    logic [31:0]    m_rdata = '0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model, updated on each rising edge
    always @(posedge clk) begin
        logic [NCH-1:0] w;
        logic [31:0]    nrd;
        bit             clr;
        w   = bus_wdata[NCH-1:0];
        nrd = 0;
        clr = 0;
        if (!rst_n) begin
            m_mode = 0; m_en = 0; m_mask = 0; m_pend = 0; m_rdata = 0;
        end else begin
            if (bus_sel && bus_addr < 32 && bus_addr[1:0] == 0) begin
                if (bus_wr) begin
                    case (int'(bus_addr) / 4)
                        0: m_mode = bus_wdata;
                        1: m_en   = m_en | w;
                        2: m_en   = m_en & ~w;
                        4: m_mask = m_mask | w;
                        5: m_mask = m_mask & ~w;
                        default: ;
                    endcase
                end else begin
                    case (int'(bus_addr) / 4)
                        0: nrd = m_mode;
                        3: nrd = 32'(m_en);
                        6: nrd = 32'(m_mask);
                        7: begin nrd = 32'(m_pend); clr = 1; end
                        default: nrd = 0;
                    endcase
                end
            end
            m_pend  = (clr ? '0 : m_pend) | chan_evt;
            m_rdata = nrd;
        end
        rd_tag = cur_tag;
    end

    // Compare the design with the model after the inputs have settled
    always @(negedge clk) begin
        int  a;
        bit  hit;
        #1;
        if (cmp_on) begin
            a   = int'(bus_addr);
            hit = bus_sel && a >= 'h200 && ((a - 'h200) / 32) < NCH;
            chk("R2 R3", "chan_en", 32'(chan_en), 32'(m_en));
            chk("R8", "irq", 32'(irq), 32'(|(m_pend & m_mask)));
            chk("R9", "mode_cfg", mode_cfg, m_mode);
            chk(rd_tag, "bus_rdata", bus_rdata, m_rdata);
            chk("R10", "win_sel", 32'(win_sel), 32'(hit));
            if (hit) begin
                chk("R10", "win_chan", 32'(win_chan), 32'((a - 'h200) / 32));
                chk("R10", "win_off", 32'(win_off), 32'(a % 32));
            end
        end
    end

    task automatic cyc(bit sel, bit wr, int addr, logic [31:0] data,
                       logic [NCH-1:0] evt, string tag);
        @(negedge clk);
        bus_sel   = sel;
        bus_wr    = wr;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        chan_evt  = evt;
        cur_tag   = tag;
    endtask

    task automatic wr(int addr, logic [31:0] data, string tag);
        cyc(1, 1, addr, data, '0, tag);
    endtask

    task automatic rd(int addr, string tag);
        cyc(1, 0, addr, 0, '0, tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, '0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: state after reset
        chk("R1", "chan_en", 32'(chan_en), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "mode_cfg", mode_cfg, 0);
        cmp_on = 1;
        rd('h0C, "R1"); rd('h18, "R1"); rd('h1C, "R1"); idle("R1");
        // R2: start with the write-one behaviour
        wr('h04, 32'h5, "R2"); wr('h04, 32'h2, "R2"); rd('h0C, "R2");
        // R3: stop
        wr('h08, 32'h1, "R3"); rd('h0C, "R3");
        // R4: bits above the channel count have no effect
        wr('h04, 32'hFFFF_FFF0, "R4"); wr('h10, 32'hFFFF_FFF0, "R4");
        rd('h0C, "R4"); rd('h18, "R4");
        // R5: set and clear the mask, and ignored writes
        wr('h10, 32'h3, "R5"); rd('h18, "R5");
        wr('h14, 32'h1, "R5"); rd('h18, "R5");
        wr('h18, 32'hF, "R5"); wr('h0C, 32'hF, "R5"); wr('h1C, 32'hF, "R5");
        rd('h18, "R5"); rd('h0C, "R5");
        // R6: an event becomes pending, and a read clears it
        cyc(0, 0, 0, 0, 4'b0001, "R6"); idle("R6");
        rd('h1C, "R6"); rd('h1C, "R6");
        // R7: an event in the same cycle as a pending read
        cyc(0, 0, 0, 0, 4'b0010, "R7");
        cyc(1, 0, 'h1C, 0, 4'b0100, "R7");
        rd('h1C, "R7"); rd('h1C, "R7");
        // R8: only pending and unmasked channels raise the interrupt (mask is 0010)
        cyc(0, 0, 0, 0, 4'b0001, "R8"); idle("R8"); idle("R8");
        cyc(0, 0, 0, 0, 4'b0010, "R8"); idle("R8");
        rd('h1C, "R8"); idle("R8");
        // R9: mode register
        wr('h00, 32'hA5A5_1234, "R9"); rd('h00, "R9");
        // R10: window decode
        rd('h200, "R10"); wr('h21C, 32'h1, "R10"); rd('h268, "R10");
        rd('h280, "R10"); rd('h100, "R10"); rd('h7E0, "R10");
        // R11: read timing, non-global and unaligned reads
        rd('h05, "R11"); rd('h240, "R11"); rd('h20, "R11"); idle("R11");
        // Mixed random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            int sel_a;
            int a;
            sel_a = int'($urandom_range(0, 9));
            if (sel_a < 8) a = sel_a * 4;
            else           a = 'h1E0 + int'($urandom_range(0, 8)) * 32 + int'($urandom_range(0, 31));
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom(),
                NCH'($urandom()) & NCH'($urandom()), "R6");
        end
        idle("R11"); idle("R11");
        finish_run();
    end
endmodule